// File: doc/BRIEF.md
# Float-to-Integer Saturating Converter

This block turns a floating-point register value into an integer destination value in one combinational pass. The source is either single or double precision, and the destination is a signed or unsigned integer of 32 or 64 bits. The fractional part is always discarded, so the result is rounded toward zero. Any input that cannot be represented produces a fixed saturation value, and the invalid flag is raised.

An execute stage places the raw 64-bit register contents on the input, together with a precision select and a two-bit conversion kind. It then takes the 64-bit result and the flag in the same cycle. A 32-bit result always fills the whole 64-bit destination, extended from its bit 31.

Top module: `f2i_conv`

## Requirements
- R1: `kind_i` selects the destination: 2'b00 signed 32, 2'b01 unsigned 32, 2'b10 signed 64, 2'b11 unsigned 64. `dbl_i`=1 selects double precision and `dbl_i`=0 selects single.
- R2: An in-range finite input is truncated toward zero. For example, 2.7 gives 2 and -2.7 gives -2.
- R3: A NaN converted to a signed kind gives the largest positive value of the target width (0x7FFFFFFF, or 0x7FFFFFFFFFFFFFFF) and sets `invalid_o`.
- R4: A NaN converted to an unsigned kind gives all ones across all 64 bits and sets `invalid_o`.
- R5: For a signed kind, an input whose truncated value is above the signed range, or is positive infinity, gives the signed maximum. An input whose truncated value is below the range, or is negative infinity, gives the signed minimum. Both cases set `invalid_o`.
- R6: A truncated value that equals exactly the most negative signed value (-2^31 or -2^63) is converted without setting `invalid_o`.
- R7: For an unsigned kind, any negative nonzero input gives 0 and sets `invalid_o`. This includes fractions such as -0.5 and negative subnormals. Negative zero gives 0 with `invalid_o` low.
- R8: For an unsigned kind, an input whose truncated value exceeds the target range, or is positive infinity, gives all ones across all 64 bits and sets `invalid_o`.
- R9: Every 32-bit result, signed or unsigned, is sign-extended from bit 31 into bits 63:32.
- R10: `invalid_o` is low for every representable result. Zeros and subnormals convert to 0 without setting the flag, except in the case covered by R7.
- R11: A single-precision source is taken from bits 31:0 only. Bits 63:32 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fp_bits_i | input | 64 | Raw floating-point register value |
| dbl_i | input | 1 | 1: double precision source, 0: single precision in the low word |
| kind_i | input | 2 | Destination kind (see R1) |
| int_o | output | 64 | Integer destination value |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
The bench aims at the edges of each range: exactly 2^31, exactly -2^31, -(2^31+1), 2^32-1, 2^63 and 2^64. A range check that is off by one would either saturate a legal minimum or let a wrapped value through without the flag. Negative zero, -0.5 and negative subnormals sent to unsigned kinds separate a sign test from a magnitude test. NaN and the infinities are sent to all four kinds, so a swapped saturation table is caught. Unsigned 32-bit results with bit 31 set, and single-precision inputs carrying garbage in the upper word, expose a missing sign extension or a source word taken from the wrong half.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  parameter int XLEN     = 64;
  parameter int HALF_W   = XLEN / 2;
  parameter int DP_EXP_W = 11;
  parameter int DP_MAN_W = 52;
  parameter int SP_EXP_W = 8;
  parameter int SP_MAN_W = 23;
  parameter int DP_BIAS  = 1023;
  parameter int SP_BIAS  = 127;
  parameter int EXP_W    = DP_EXP_W + 2;
  parameter int SIG_W    = DP_MAN_W + 1;
  parameter int SHIFT_W  = $clog2(XLEN);

  typedef enum logic [1:0] {
    KIND_S32 = 2'b00,
    KIND_U32 = 2'b01,
    KIND_S64 = 2'b10,
    KIND_U64 = 2'b11
  } conv_kind_e;

  typedef struct packed {
    logic                    sign;
    logic                    nan;
    logic                    inf;
    logic                    zero;
    logic                    tiny;   // zero or subnormal: magnitude below one
    logic signed [EXP_W-1:0] exp;
    logic [SIG_W-1:0]        sig;    // hidden bit at SIG_W-1
  } fp_fields_t;
endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
  import f2i_pkg::*;
(
  input  logic [XLEN-1:0] raw_i,
  input  logic            dbl_i,
  output fp_fields_t      fp_o
);
  localparam int PAD_W = DP_MAN_W - SP_MAN_W;

  logic [DP_EXP_W-1:0] e_d;
  logic [DP_MAN_W-1:0] m_d;
  logic [SP_EXP_W-1:0] e_s;
  logic [SP_MAN_W-1:0] m_s;
  logic exp_max, exp_zero, frac_nz;

  assign e_d = raw_i[XLEN-2 -: DP_EXP_W];
  assign m_d = raw_i[DP_MAN_W-1:0];
  assign e_s = raw_i[HALF_W-2 -: SP_EXP_W];
  assign m_s = raw_i[SP_MAN_W-1:0];

  always_comb begin
    fp_o = '0;
    if (dbl_i) begin
      fp_o.sign = raw_i[XLEN-1];
      exp_max   = &e_d;
      exp_zero  = ~|e_d;
      frac_nz   = |m_d;
      fp_o.exp  = EXP_W'(e_d) - EXP_W'(DP_BIAS);
      fp_o.sig  = {1'b1, m_d};
    end else begin
      fp_o.sign = raw_i[HALF_W-1];
      exp_max   = &e_s;
      exp_zero  = ~|e_s;
      frac_nz   = |m_s;
      fp_o.exp  = EXP_W'(e_s) - EXP_W'(SP_BIAS);
      fp_o.sig  = {1'b1, m_s, {PAD_W{1'b0}}};
    end
    fp_o.nan  = exp_max & frac_nz;
    fp_o.inf  = exp_max & ~frac_nz;
    fp_o.zero = exp_zero & ~frac_nz;
    fp_o.tiny = exp_zero;
  end
endmodule

// File: rtl/f2i_trunc.sv
module f2i_trunc
  import f2i_pkg::*;
(
  input  fp_fields_t      fp_i,
  output logic [XLEN-1:0] mag_o,
  output logic            huge_o
);
  localparam int WIDE_W = SIG_W + XLEN - 1;
  localparam logic signed [EXP_W-1:0] EXP_LIM = EXP_W'(XLEN - 1);

  logic [WIDE_W-1:0] wide;

  // Fixed point at bit SIG_W-1; shifting left by the exponent leaves the
  // integer part in the top XLEN bits, the fraction below is dropped.
  always_comb begin
    mag_o  = '0;
    huge_o = 1'b0;
    wide   = '0;
    if (fp_i.nan || fp_i.inf) begin
      huge_o = 1'b1;
    end else if (fp_i.tiny || fp_i.exp[EXP_W-1]) begin
      mag_o = '0;
    end else if (fp_i.exp > EXP_LIM) begin
      huge_o = 1'b1;
    end else begin
      wide  = WIDE_W'(fp_i.sig) << fp_i.exp[SHIFT_W-1:0];
      mag_o = wide[WIDE_W-1 -: XLEN];
    end
  end
endmodule

// File: rtl/f2i_sat.sv
module f2i_sat
  import f2i_pkg::*;
(
  input  logic            sign_i,
  input  logic            nan_i,
  input  logic            zero_i,
  input  logic [XLEN-1:0] mag_i,
  input  logic            huge_i,
  input  conv_kind_e      kind_i,
  output logic [XLEN-1:0] res_o,
  output logic            inv_o
);
  logic is_signed, is_narrow;
  logic [XLEN-1:0] s_max, s_min, pos_lim, neg_lim, uns_lim;
  logic [XLEN-1:0] raw;

  assign is_signed = ~kind_i[0];
  assign is_narrow = ~kind_i[1];

  generate
    always_comb begin
      if (is_narrow) begin
        pos_lim = XLEN'({1'b0, {(HALF_W-1){1'b1}}});
        neg_lim = XLEN'({1'b1, {(HALF_W-1){1'b0}}});
        uns_lim = XLEN'({HALF_W{1'b1}});
        s_min   = {{(HALF_W+1){1'b1}}, {(HALF_W-1){1'b0}}};
      end else begin
        pos_lim = {1'b0, {(XLEN-1){1'b1}}};
        neg_lim = {1'b1, {(XLEN-1){1'b0}}};
        uns_lim = '1;
        s_min   = {1'b1, {(XLEN-1){1'b0}}};
      end
      s_max = pos_lim;
    end
  endgenerate

  always_comb begin
    inv_o = 1'b0;
    raw   = '0;
    if (nan_i) begin
      inv_o = 1'b1;
      raw   = is_signed ? s_max : '1;
    end else if (is_signed) begin
      if (!sign_i) begin
        if (huge_i || mag_i > pos_lim) begin
          inv_o = 1'b1;
          raw   = s_max;
        end else begin
          raw = mag_i;
        end
      end else begin
        if (huge_i || mag_i > neg_lim) begin
          inv_o = 1'b1;
          raw   = s_min;
        end else begin
          raw = -mag_i;
        end
      end
    end else begin
      if (sign_i && !zero_i) begin
        inv_o = 1'b1;
        raw   = '0;
      end else if (huge_i || mag_i > uns_lim) begin
        inv_o = 1'b1;
        raw   = '1;
      end else begin
        raw = mag_i;
      end
    end
  end

  always_comb begin
    res_o = raw;
    if (is_narrow && !inv_o) res_o = {{HALF_W{raw[HALF_W-1]}}, raw[HALF_W-1:0]};
  end
endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
  import f2i_pkg::*;
(
  input  logic [63:0] fp_bits_i,
  input  logic        dbl_i,
  input  logic [1:0]  kind_i,
  output logic [63:0] int_o,
  output logic        invalid_o
);
  fp_fields_t      fp;
  logic [XLEN-1:0] mag;
  logic            huge;

  f2i_unpack u_unpack (
    .raw_i (fp_bits_i),
    .dbl_i (dbl_i),
    .fp_o  (fp)
  );

  f2i_trunc u_trunc (
    .fp_i   (fp),
    .mag_o  (mag),
    .huge_o (huge)
  );

  f2i_sat u_sat (
    .sign_i (fp.sign),
    .nan_i  (fp.nan),
    .zero_i (fp.zero),
    .mag_i  (mag),
    .huge_i (huge),
    .kind_i (conv_kind_e'(kind_i)),
    .res_o  (int_o),
    .inv_o  (invalid_o)
  );
endmodule

// File: rtl/f2i_conv_chk.sv
module f2i_conv_chk (
  input logic [63:0] fp_bits_i,
  input logic        dbl_i,
  input logic [1:0]  kind_i,
  input logic [63:0] int_o,
  input logic        invalid_o
);
  logic in_nan, in_neg, in_zero, sat_ok;

  always_comb begin
    if (dbl_i) begin
      in_nan  = (&fp_bits_i[62:52]) && (|fp_bits_i[51:0]);
      in_neg  = fp_bits_i[63];
      in_zero = ~|fp_bits_i[62:0];
    end else begin
      in_nan  = (&fp_bits_i[30:23]) && (|fp_bits_i[22:0]);
      in_neg  = fp_bits_i[31];
      in_zero = ~|fp_bits_i[30:0];
    end
    sat_ok = int_o == 64'h7FFF_FFFF_FFFF_FFFF || int_o == 64'h0000_0000_7FFF_FFFF ||
             int_o == 64'h8000_0000_0000_0000 || int_o == 64'hFFFF_FFFF_8000_0000 ||
             int_o == 64'h0 || int_o == 64'hFFFF_FFFF_FFFF_FFFF;
  end

  always_comb begin
    if (!$isunknown({fp_bits_i, dbl_i, kind_i})) begin
      AST_NAN_SIGNED: assert (!(in_nan && !kind_i[0]) || (invalid_o && int_o == (kind_i[1] ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF))); // R3
      AST_NAN_UNSIGNED: assert (!(in_nan && kind_i[0]) || (invalid_o && int_o == 64'hFFFF_FFFF_FFFF_FFFF)); // R4
      AST_SAT_VALUE: assert (!invalid_o || sat_ok); // R5
      AST_UNS_NEGATIVE: assert (!(kind_i[0] && in_neg && !in_nan && !in_zero) || (invalid_o && int_o == 64'h0)); // R7
      AST_NARROW_SEXT: assert (kind_i[1] || int_o[63:32] == {32{int_o[31]}}); // R9
      AST_VALID_SIGN: assert (invalid_o || kind_i[0] || int_o == 64'h0 || int_o[63] == in_neg); // R2
    end
  end
endmodule

bind f2i_conv f2i_conv_chk u_chk (.*);

// File: tb/tb_f2i_conv.sv
module tb_f2i_conv;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [63:0] fp_bits;
  logic        dbl;
  logic [1:0]  kind;
  logic [63:0] res;
  logic        inv;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  f2i_conv dut (
    .fp_bits_i (fp_bits),
    .dbl_i     (dbl),
    .kind_i    (kind),
    .int_o     (res),
    .invalid_o (inv)
  );

  // Behavioural reference built from the requirements.
  function automatic logic [64:0] ref_conv(logic [63:0] b, logic d, logic [1:0] k);
    int ebits, emax, fw, e;
    logic [63:0] frac, sig, mag, r;
    bit s, nan, inf, nonzero, big, iv, wide, sgn;
    if (d) begin
      s = b[63]; ebits = int'(b[62:52]); frac = {12'd0, b[51:0]}; fw = 52; emax = 2047; e = ebits - 1023;
    end else begin
      s = b[31]; ebits = int'(b[30:23]); frac = {41'd0, b[22:0]}; fw = 23; emax = 255; e = ebits - 127;
    end
    nan = (ebits == emax) && (frac != 0);
    inf = (ebits == emax) && (frac == 0);
    nonzero = (ebits != 0) || (frac != 0);
    big = inf; mag = 0; iv = 0; r = 0;
    wide = k[1]; sgn = !k[0];
    if (!nan && !inf && ebits != 0 && e >= 0) begin
      if (e > 63) big = 1;
      else begin
        sig = frac | (64'd1 << fw);
        mag = (e >= fw) ? (sig << (e - fw)) : (sig >> (fw - e));
      end
    end
    if (nan) begin
      iv = 1; r = sgn ? (wide ? 64'h7FFFFFFFFFFFFFFF : 64'h7FFFFFFF) : '1;
    end else if (sgn) begin
      if (!s && (big || mag > (wide ? 64'h7FFFFFFFFFFFFFFF : 64'h7FFFFFFF))) begin
        iv = 1; r = wide ? 64'h7FFFFFFFFFFFFFFF : 64'h7FFFFFFF;
      end else if (s && (big || mag > (wide ? 64'h8000000000000000 : 64'h80000000))) begin
        iv = 1; r = wide ? 64'h8000000000000000 : 64'hFFFFFFFF80000000;
      end else r = s ? (64'd0 - mag) : mag;
    end else begin
      if (s && nonzero) begin iv = 1; r = 0; end
      else if (big || mag > (wide ? 64'hFFFFFFFFFFFFFFFF : 64'hFFFFFFFF)) begin iv = 1; r = '1; end
      else r = mag;
    end
    if (!wide && !iv) r = {{32{r[31]}}, r[31:0]};
    return {iv, r};
  endfunction

  task automatic check(string tag, logic [63:0] b, logic d, logic [1:0] k, logic exp_inv, logic [63:0] exp_res);
    @(posedge clk);
    #1;
    fp_bits = b; dbl = d; kind = k;
    @(negedge clk);
    n_chk++;
    if (res !== exp_res || inv !== exp_inv) begin
      n_fail++;
      $display("FAIL %s in=%h dbl=%0b kind=%0d actual=%h/%0b expected=%h/%0b",
               tag, b, d, k, res, inv, exp_res, exp_inv);
    end
  endtask

  task automatic check_ref(string tag, logic [63:0] b, logic d, logic [1:0] k);
    logic [64:0] e;
    e = ref_conv(b, d, k);
    check(tag, b, d, k, e[64], e[63:0]);
  endtask

  initial begin
    fp_bits = '0; dbl = 1'b0; kind = 2'b00;
    // reset state: zero input gives zero, flag low
    check("R10 zero", 64'h0, 1'b1, 2'b10, 1'b0, 64'h0);
    // R1 kind encoding, -2.7 double through all four kinds
    check("R1 s32", 64'hC00599999999999A, 1'b1, 2'b00, 1'b0, 64'hFFFFFFFFFFFFFFFE);
    check("R1 u32", 64'hC00599999999999A, 1'b1, 2'b01, 1'b1, 64'h0);
    check("R1 s64", 64'hC00599999999999A, 1'b1, 2'b10, 1'b0, 64'hFFFFFFFFFFFFFFFE);
    check("R1 u64", 64'hC00599999999999A, 1'b1, 2'b11, 1'b1, 64'h0);
    // R2 truncation
    check("R2 dp 2.7", 64'h400599999999999A, 1'b1, 2'b10, 1'b0, 64'd2);
    check("R2 sp 2.7", 64'h00000000402CCCCD, 1'b0, 2'b00, 1'b0, 64'd2);
    check("R2 sp -2.7", 64'h00000000C02CCCCD, 1'b0, 2'b10, 1'b0, 64'hFFFFFFFFFFFFFFFE);
    // R3 / R4 NaN
    check("R3 nan s32", 64'h7FF8000000000000, 1'b1, 2'b00, 1'b1, 64'h7FFFFFFF);
    check("R3 nan s64", 64'h000000007FC00000, 1'b0, 2'b10, 1'b1, 64'h7FFFFFFFFFFFFFFF);
    check("R4 nan u32", 64'h000000007FC00000, 1'b0, 2'b01, 1'b1, 64'hFFFFFFFFFFFFFFFF);
    check("R4 nan u64", 64'hFFF8000000000001, 1'b1, 2'b11, 1'b1, 64'hFFFFFFFFFFFFFFFF);
    // R5 signed saturation
    check("R5 2^31 s32", 64'h41E0000000000000, 1'b1, 2'b00, 1'b1, 64'h7FFFFFFF);
    check("R5 -(2^31+1) s32", 64'hC1E0000000200000, 1'b1, 2'b00, 1'b1, 64'hFFFFFFFF80000000);
    check("R5 2^63 s64", 64'h43E0000000000000, 1'b1, 2'b10, 1'b1, 64'h7FFFFFFFFFFFFFFF);
    check("R5 +inf s64", 64'h7FF0000000000000, 1'b1, 2'b10, 1'b1, 64'h7FFFFFFFFFFFFFFF);
    check("R5 -inf s32", 64'hFFF0000000000000, 1'b1, 2'b00, 1'b1, 64'hFFFFFFFF80000000);
    // R6 exact minimum
    check("R6 -2^31 s32", 64'hC1E0000000000000, 1'b1, 2'b00, 1'b0, 64'hFFFFFFFF80000000);
    check("R6 -2^63 s64", 64'hC3E0000000000000, 1'b1, 2'b10, 1'b0, 64'h8000000000000000);
    // R7 negative to unsigned
    check("R7 -0.5 u64", 64'hBFE0000000000000, 1'b1, 2'b11, 1'b1, 64'h0);
    check("R7 -0.0 u64", 64'h8000000000000000, 1'b1, 2'b11, 1'b0, 64'h0);
    check("R7 -subnormal u32", 64'h8000000000000001, 1'b1, 2'b01, 1'b1, 64'h0);
    check("R7 -inf u64", 64'hFFF0000000000000, 1'b1, 2'b11, 1'b1, 64'h0);
    // R8 unsigned overflow
    check("R8 2^32 u32", 64'h41F0000000000000, 1'b1, 2'b01, 1'b1, 64'hFFFFFFFFFFFFFFFF);
    check("R8 2^64 u64", 64'h43F0000000000000, 1'b1, 2'b11, 1'b1, 64'hFFFFFFFFFFFFFFFF);
    check("R8 +inf u32", 64'h7FF0000000000000, 1'b1, 2'b01, 1'b1, 64'hFFFFFFFFFFFFFFFF);
    check("R8 max below 2^64", 64'h43EFFFFFFFFFFFFF, 1'b1, 2'b11, 1'b0, 64'hFFFFFFFFFFFFF800);
    // R9 sign extension of 32-bit results
    check("R9 2^31 u32", 64'h41E0000000000000, 1'b1, 2'b01, 1'b0, 64'hFFFFFFFF80000000);
    check("R9 2^32-1 u32", 64'h41EFFFFFFFE00000, 1'b1, 2'b01, 1'b0, 64'hFFFFFFFFFFFFFFFF);
    // R10 subnormal and -0.5 signed
    check("R10 subnormal", 64'h0000000000000001, 1'b1, 2'b11, 1'b0, 64'h0);
    check("R10 -0.5 s64", 64'hBFE0000000000000, 1'b1, 2'b10, 1'b0, 64'h0);
    // R11 upper word ignored for single precision
    check("R11 sp 1.0 garbage", 64'hDEADBEEF3F800000, 1'b0, 2'b11, 1'b0, 64'd1);
    check("R11 sp nan garbage", 64'h123456787FC00001, 1'b0, 2'b00, 1'b1, 64'h7FFFFFFF);
    // sweep against the reference model, exponents near the limits
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] b;
      logic d;
      logic [1:0] k;
      d = 1'($urandom);
      k = 2'($urandom);
      b = {$urandom, $urandom};
      if (i % 4 != 0) begin
        if (d) b[62:52] = 11'(1023 - 3 + ($urandom % 70));
        else   b[30:23] = 8'(127 - 3 + ($urandom % 70));
      end
      check_ref("R2 R5 R8 R9 sweep", b, d, k);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule